// File: doc/BRIEF.md
# Shadowed Register Bus Wrapper

This block sits between a simple system-bus slave port and a core's internal register bus. It keeps a local shadow copy of each of the core's registers, together with a valid flag per copy. A system-bus read of a register whose copy is valid is answered in the same cycle from the copy, and the internal bus is not touched. A read of a register whose copy is not yet valid stalls the system bus with a ready signal and triggers a demand fetch. Once the fetch lands, the read is served from the copy.

System-bus writes are forwarded to the core over the internal bus. When the write completes, the written value is also stored in the copy, so a later read never returns older data. A separate refresh port lets an external scheduler ask for a copy to be reloaded from the core. The scheduling policy itself lives outside the block. One refresh request can be held pending while the internal bus is busy.

Every internal-bus transfer lasts exactly two cycles. A transfer that has started always finishes. When the bus is free, new work is chosen in a fixed order: a system write first, then a demand fetch for a stalled read, then a pending refresh.

Top module: `regPrefetchWrap`

## Requirements
- R1: After reset every valid flag is clear, `intReq` is low and `pfIdle` is high, so the first read of any index stalls.
- R2: A read (`sysSel`=1, `sysWr`=0) of an index whose copy is valid sees `sysReady`=1 in the same cycle, with `sysRdata` equal to the copy. The read itself starts no internal-bus transfer.
- R3: A read of an index whose copy is invalid, made on an idle bus, holds `sysReady` low for 3 cycles. It then returns the core's value for that index. The demand fetch uses `intWr`=0 and `intIdx` equal to the read index.
- R4: Each internal transfer holds `intReq` high for exactly two consecutive cycles, with `intIdx`, `intWr` and `intWdata` stable. The core acts on the second cycle, and `intReq` then drops for at least one cycle.
- R5: A write made on an idle bus drives `intWr`=1 with `intWdata` equal to the written value. `sysReady` rises in the second transfer cycle, so there are 2 waiting cycles. The copy takes the written value on the same edge, and a later read returns it without a stall.
- R6: When the bus is free and several requests wait, the write wins over a pending refresh, and a demand fetch also wins over a pending refresh.
- R7: A refresh request (`pfReq`=1 while `pfIdle`=1) is accepted on that edge. `pfIdle` is low from the next cycle until the refresh transfer starts, including while a write occupies the bus.
- R8: When a refresh transfer completes, the copy holds the core's current value and its valid flag is set. Until then, a read returns the older copy.
- R9: A transfer already in progress is never preempted. A write arriving during the first cycle of a refresh waits 4 cycles for `sysReady`, and the core ends up holding the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sysSel | input | 1 | System-bus request, held until `sysReady` |
| sysWr | input | 1 | 1 = write, 0 = read |
| sysIdx | input | IDX_W (3) | Register index |
| sysWdata | input | DATA_W (32) | Write data |
| sysRdata | output | DATA_W (32) | Read data, valid when `sysReady` on a read |
| sysReady | output | 1 | Transfer completes this cycle |
| pfReq | input | 1 | Refresh request from the scheduler |
| pfIdx | input | IDX_W (3) | Index to refresh |
| pfIdle | output | 1 | A refresh request can be accepted |
| intReq | output | 1 | Internal-bus transfer active |
| intWr | output | 1 | Internal transfer is a write |
| intIdx | output | IDX_W (3) | Internal transfer index |
| intWdata | output | DATA_W (32) | Internal write data |
| intRdata | input | DATA_W (32) | Core read data, sampled on the second transfer cycle |

## Verification
Each result has a fixed due cycle:
- A read hit is answered in the cycle it is presented.
- A read miss is answered on the fourth falling edge: one cycle for arbitration and two bus cycles.
- A write on an idle bus is answered on the third falling edge.
- `pfIdle` falls one cycle after a request is accepted.

The bench's behavioural model advances on each rising edge, using only the inputs it drove. It compares every output on the following falling edge, so each check lands in the cycle the requirement names. Scripted cases also count waiting cycles and record the order in which transfers start. These counts pin down the latency and arbitration figures above.

// File: rtl/wrapPkg.sv
package wrapPkg;
  typedef enum logic [1:0] {PH_IDLE, PH_FIRST, PH_SECOND} busPhase_t;
  typedef enum logic [1:0] {OWN_WRITE, OWN_DEMAND, OWN_REFRESH} busOwner_t;
  typedef struct packed {
    logic holdWdata;
    logic commit;
    logic fromWrite;
  } dpStrobe_t;
endpackage

// File: rtl/wrapCtrl.sv
module wrapCtrl
  import wrapPkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sysSel,
  input  logic             sysWr,
  input  logic             hitValid,
  input  logic             pfReq,
  input  logic [IDX_W-1:0] pfIdx,
  input  logic [IDX_W-1:0] sysIdx,
  output logic             sysReady,
  output logic             pfIdle,
  output logic             intReq,
  output logic             intWr,
  output logic [IDX_W-1:0] intIdx,
  output dpStrobe_t        strobe
);
  busPhase_t        phase;
  busOwner_t        owner;
  logic [IDX_W-1:0] curIdx;
  logic             pfPend;
  logic [IDX_W-1:0] pfPendIdx;
  logic             wantWrite, wantDemand, busFree, startPf;

  always_comb begin
    wantWrite  = sysSel & sysWr;
    wantDemand = sysSel & ~sysWr & ~hitValid;
    busFree    = (phase == PH_IDLE);
    startPf    = busFree & ~wantWrite & ~wantDemand & pfPend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      owner  <= OWN_REFRESH;
      curIdx <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (wantWrite) begin
            phase <= PH_FIRST; owner <= OWN_WRITE; curIdx <= sysIdx;
          end else if (wantDemand) begin
            phase <= PH_FIRST; owner <= OWN_DEMAND; curIdx <= sysIdx;
          end else if (pfPend) begin
            phase <= PH_FIRST; owner <= OWN_REFRESH; curIdx <= pfPendIdx;
          end
        end
        PH_FIRST:  phase <= PH_SECOND;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pfPend    <= 1'b0;
      pfPendIdx <= '0;
    end else if (pfReq && !pfPend) begin
      pfPend    <= 1'b1;
      pfPendIdx <= pfIdx;
    end else if (startPf) begin
      pfPend    <= 1'b0;
    end
  end

  always_comb begin
    strobe.holdWdata = busFree & wantWrite;
    strobe.commit    = (phase == PH_SECOND);
    strobe.fromWrite = (owner == OWN_WRITE);
    intReq   = ~busFree;
    intWr    = intReq & (owner == OWN_WRITE);
    intIdx   = curIdx;
    pfIdle   = ~pfPend;
    sysReady = sysSel & (sysWr ? ((phase == PH_SECOND) && (owner == OWN_WRITE))
                               : hitValid);
  end

  // R4
  xfer_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(intReq) |=> intReq && $stable(intIdx) && $stable(intWr));
  // R4
  xfer_len_chk: assert property (@(posedge clk) disable iff (rst)
    intReq && $past(intReq) |=> !intReq);
  // R5
  wr_ready_chk: assert property (@(posedge clk) disable iff (rst)
    sysSel && sysWr && sysReady |-> intReq && intWr);
  // R6
  wr_first_chk: assert property (@(posedge clk) disable iff (rst)
    !intReq && sysSel && sysWr && !pfIdle |=> intWr && !pfIdle);
  // R7
  pf_accept_chk: assert property (@(posedge clk) disable iff (rst)
    pfReq && pfIdle |=> !pfIdle);
endmodule

// File: rtl/wrapDatapath.sv
module wrapDatapath
  import wrapPkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  curIdx,
  input  logic [IDX_W-1:0]  sysIdx,
  input  logic [DATA_W-1:0] sysWdata,
  input  logic [DATA_W-1:0] intRdata,
  output logic [DATA_W-1:0] sysRdata,
  output logic              hitValid,
  output logic [DATA_W-1:0] intWdata
);
  logic [DATA_W-1:0] shadow [NUM_REGS];
  logic [NUM_REGS-1:0] validVec;
  logic [DATA_W-1:0] wdataHold;
  logic [DATA_W-1:0] landData;

  assign landData = strobe.fromWrite ? wdataHold : intRdata;

  always_ff @(posedge clk) begin
    if (rst) wdataHold <= '0;
    else if (strobe.holdWdata) wdataHold <= sysWdata;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gShadow
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow[g]   <= '0;
        validVec[g] <= 1'b0;
      end else if (strobe.commit && curIdx == IDX_W'(g)) begin
        shadow[g]   <= landData;
        validVec[g] <= 1'b1;
      end
    end
  end

  assign sysRdata = shadow[sysIdx];
  assign hitValid = validVec[sysIdx];
  assign intWdata = wdataHold;

  // R5
  wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.commit && strobe.fromWrite |=> shadow[$past(curIdx)] == $past(intWdata));
  // R8
  fill_valid_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.commit |=> validVec[$past(curIdx)]);
endmodule

// File: rtl/regPrefetchWrap.sv
module regPrefetchWrap
  import wrapPkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sysSel,
  input  logic              sysWr,
  input  logic [IDX_W-1:0]  sysIdx,
  input  logic [DATA_W-1:0] sysWdata,
  output logic [DATA_W-1:0] sysRdata,
  output logic              sysReady,
  input  logic              pfReq,
  input  logic [IDX_W-1:0]  pfIdx,
  output logic              pfIdle,
  output logic              intReq,
  output logic              intWr,
  output logic [IDX_W-1:0]  intIdx,
  output logic [DATA_W-1:0] intWdata,
  input  logic [DATA_W-1:0] intRdata
);
  dpStrobe_t strobe;
  logic      hitValid;

  wrapCtrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .sysSel(sysSel), .sysWr(sysWr), .hitValid(hitValid),
    .pfReq(pfReq), .pfIdx(pfIdx), .sysIdx(sysIdx), .sysReady(sysReady),
    .pfIdle(pfIdle), .intReq(intReq), .intWr(intWr), .intIdx(intIdx),
    .strobe(strobe)
  );

  wrapDatapath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .curIdx(intIdx), .sysIdx(sysIdx),
    .sysWdata(sysWdata), .intRdata(intRdata), .sysRdata(sysRdata),
    .hitValid(hitValid), .intWdata(intWdata)
  );
endmodule

// File: tb/regPrefetchWrap_tb.sv
module regPrefetchWrap_tb;
  localparam int CLK_P = 10;
  localparam int NR = 8;

  logic clk = 0, rst = 1;
  logic sysSel = 0, sysWr = 0, pfReq = 0;
  logic [2:0] sysIdx = 0, pfIdx = 0;
  logic [31:0] sysWdata = 0;
  logic [31:0] sysRdata, intWdata, intRdata;
  logic sysReady, pfIdle, intReq, intWr;
  logic [2:0] intIdx;

  logic mutReq = 0;
  logic [2:0] mutIdx = 0;
  logic [31:0] mutVal = 0;

  int total = 0, bad = 0;

  logic [31:0] coreRegs [NR];
  logic [31:0] mShadow [NR];
  logic mValid [NR];
  int mBusy, mOwn;
  logic [2:0] mIdx, mPendIdx;
  logic [31:0] mWd;
  logic mPend;
  int startLog[$];

  always #(CLK_P/2) clk = ~clk;

  assign intRdata = coreRegs[intIdx];

  regPrefetchWrap u_dut (
    .clk(clk), .rst(rst), .sysSel(sysSel), .sysWr(sysWr), .sysIdx(sysIdx),
    .sysWdata(sysWdata), .sysRdata(sysRdata), .sysReady(sysReady),
    .pfReq(pfReq), .pfIdx(pfIdx), .pfIdle(pfIdle), .intReq(intReq),
    .intWr(intWr), .intIdx(intIdx), .intWdata(intWdata), .intRdata(intRdata)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: core registers plus wrapper state
  always @(posedge clk) begin
    logic acc;
    if (rst) begin
      mBusy = 0; mOwn = 2; mPend = 0; mIdx = 0; mPendIdx = 0; mWd = 0;
      for (int k = 0; k < NR; k++) begin
        mValid[k] = 0; mShadow[k] = 0; coreRegs[k] = 32'hC0DE_0000 + k * 32'h0101;
      end
    end else begin
      acc = pfReq && !mPend;
      if (mBusy == 2) begin
        if (mOwn == 0) begin coreRegs[mIdx] = mWd; mShadow[mIdx] = mWd; end
        else mShadow[mIdx] = coreRegs[mIdx];
        mValid[mIdx] = 1; mBusy = 0;
      end else if (mBusy == 1) begin
        mBusy = 2;
      end else if (sysSel && sysWr) begin
        mOwn = 0; mIdx = sysIdx; mWd = sysWdata; mBusy = 1; startLog.push_back(int'(sysIdx));
      end else if (sysSel && !mValid[sysIdx]) begin
        mOwn = 1; mIdx = sysIdx; mBusy = 1; startLog.push_back(16 + int'(sysIdx));
      end else if (mPend) begin
        mOwn = 2; mIdx = mPendIdx; mPend = 0; mBusy = 1; startLog.push_back(32 + int'(mPendIdx));
      end
      if (acc) begin mPend = 1; mPendIdx = pfIdx; end
      if (mutReq) coreRegs[mutIdx] = mutVal;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    logic expRdy;
    if (!rst) begin
      chk(intReq == (mBusy != 0), "R4 intReq", 32'(intReq), 32'(mBusy != 0));
      if (mBusy != 0) begin
        chk(intIdx == mIdx, "R4 intIdx", 32'(intIdx), 32'(mIdx));
        chk(intWr == (mOwn == 0), "R6 intWr", 32'(intWr), 32'(mOwn == 0));
        if (mOwn == 0) chk(intWdata == mWd, "R5 intWdata", intWdata, mWd);
      end
      expRdy = sysSel && (sysWr ? (mBusy == 2 && mOwn == 0) : mValid[sysIdx]);
      chk(sysReady == expRdy, "R3 sysReady", 32'(sysReady), 32'(expRdy));
      if (expRdy && !sysWr) chk(sysRdata == mShadow[sysIdx], "R2 sysRdata", sysRdata, mShadow[sysIdx]);
      chk(pfIdle == !mPend, "R7 pfIdle", 32'(pfIdle), 32'(!mPend));
    end
  end

  task automatic stepIn();
    @(posedge clk); #1;
  endtask

  task automatic doRead(input logic [2:0] idx, output int waits, output logic [31:0] data);
    sysSel = 1; sysWr = 0; sysIdx = idx; waits = 0;
    forever begin
      @(negedge clk);
      if (sysReady) break;
      waits++;
    end
    data = sysRdata;
    stepIn(); sysSel = 0;
  endtask

  task automatic doWrite(input logic [2:0] idx, input logic [31:0] val, output int waits);
    sysSel = 1; sysWr = 1; sysIdx = idx; sysWdata = val; waits = 0;
    forever begin
      @(negedge clk);
      if (sysReady) break;
      waits++;
    end
    stepIn(); sysSel = 0; sysWr = 0;
  endtask

  task automatic firePf(input logic [2:0] idx);
    while (!pfIdle) stepIn();
    pfReq = 1; pfIdx = idx;
    stepIn(); pfReq = 0;
  endtask

  task automatic mutate(input logic [2:0] idx, input logic [31:0] val);
    mutReq = 1; mutIdx = idx; mutVal = val;
    stepIn(); mutReq = 0;
  endtask

  task automatic waitIdle();
    stepIn();
    while (intReq || !pfIdle) stepIn();
    stepIn();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired R1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w;
    logic [31:0] d;
    int n;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(intReq == 0, "R1 reset intReq", 32'(intReq), 0);
    chk(pfIdle == 1, "R1 reset pfIdle", 32'(pfIdle), 1);
    stepIn();

    // R1 / R3: first read misses
    doRead(3'd2, w, d);
    chk(w == 3, "R1/R3 miss wait", w, 3);
    chk(d == 32'hC0DE_0202, "R3 miss data", d, 32'hC0DE_0202);
    // R2: hit
    doRead(3'd2, w, d);
    chk(w == 0, "R2 hit wait", w, 0);
    chk(d == 32'hC0DE_0202, "R2 hit data", d, 32'hC0DE_0202);
    // R5: write then read back
    waitIdle();
    doWrite(3'd5, 32'h1234_5678, w);
    chk(w == 2, "R5 write wait", w, 2);
    doRead(3'd5, w, d);
    chk(w == 0, "R5 readback wait", w, 0);
    chk(d == 32'h1234_5678, "R5 readback data", d, 32'h1234_5678);
    // R8: stale until refreshed
    mutate(3'd2, 32'hBEEF_0002);
    doRead(3'd2, w, d);
    chk(d == 32'hC0DE_0202, "R8 stale copy", d, 32'hC0DE_0202);
    firePf(3'd2);
    waitIdle();
    doRead(3'd2, w, d);
    chk(w == 0 && d == 32'hBEEF_0002, "R8 refreshed", d, 32'hBEEF_0002);
    // R7: refresh of an uncached index
    firePf(3'd6);
    waitIdle();
    doRead(3'd6, w, d);
    chk(w == 0 && d == 32'hC0DE_0606, "R7 refresh hit", d, 32'hC0DE_0606);

    // R6: write beats a refresh requested in the same cycle
    waitIdle();
    pfReq = 1; pfIdx = 3'd1;
    sysSel = 1; sysWr = 1; sysIdx = 3'd0; sysWdata = 32'hAAAA_0000;
    stepIn(); pfReq = 0;
    chk(pfIdle == 0, "R7 held during write", 32'(pfIdle), 0);
    while (!sysReady) stepIn();
    stepIn(); sysSel = 0; sysWr = 0;
    waitIdle();
    n = startLog.size();
    chk(startLog[n-2] == 0, "R6 write first", startLog[n-2], 0);
    chk(startLog[n-1] == 33, "R6 refresh after", startLog[n-1], 33);

    // R6: demand fetch beats a refresh
    pfReq = 1; pfIdx = 3'd4;
    sysSel = 1; sysWr = 0; sysIdx = 3'd7;
    stepIn(); pfReq = 0;
    while (!sysReady) stepIn();
    stepIn(); sysSel = 0;
    waitIdle();
    n = startLog.size();
    chk(startLog[n-2] == 23, "R6 demand first", startLog[n-2], 23);
    chk(startLog[n-1] == 36, "R6 refresh second", startLog[n-1], 36);

    // R9: write waits for the refresh in flight
    firePf(3'd3);
    stepIn();
    doWrite(3'd3, 32'h0BAD_F00D, w);
    chk(w == 4, "R9 write wait", w, 4);
    waitIdle();
    n = startLog.size();
    chk(startLog[n-2] == 35 && startLog[n-1] == 3, "R9 order", startLog[n-1], 3);
    doRead(3'd3, w, d);
    chk(d == 32'h0BAD_F00D, "R9 final value", d, 32'h0BAD_F00D);
    chk(coreRegs[3] == 32'h0BAD_F00D, "R9 core value", coreRegs[3], 32'h0BAD_F00D);

    // mixed random traffic, checked every cycle by the reference
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0: doRead(3'($urandom_range(0, 7)), w, d);
        1: doWrite(3'($urandom_range(0, 7)), $urandom, w);
        2: firePf(3'($urandom_range(0, 7)));
        default: mutate(3'($urandom_range(0, 7)), $urandom);
      endcase
    end
    waitIdle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule